// File: doc/BRIEF.md
# Keyboard Controller Host Port

This block is the host-facing register front end of a classic PC keyboard controller. A host on an 8-bit I/O bus reaches it at two addresses. At the data address, a write hands the controller a data byte and a read collects the byte the controller has prepared. At the command address, a write hands over a command byte and a read returns a status byte. The host and the local keyboard microcontroller hand bytes to each other through one input holding register and one output holding register. A handful of status flags tell each side when a byte is waiting.

The local side sees the input byte and a flag that tells it whether the byte arrived as a command or as data. It can mark the input byte as consumed, load the output byte for the keyboard or for the auxiliary (mouse) channel, clear the auxiliary flag, and set four general-purpose status bits. Loading the output byte raises the keyboard or mouse interrupt line. The host strobes are active low and asynchronous to the block clock. Each strobe is synchronised and acts exactly once, on its falling edge.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x00, the output and input holding registers read 0x00, and both interrupt outputs are low.
- R2: A host write (write strobe low, read strobe high) at address 0x60 stores the byte in the input register, clears the command flag (status bit 3) and sets input-full (status bit 1).
- R3: A host write at address 0x64 stores the byte in the same input register, sets the command flag (status bit 3) and sets input-full (status bit 1).
- R4: While the read strobe is low and the write strobe is high, address 0x60 drives the output register and address 0x64 drives the status byte, and the output enable is high. The status layout is: bit 0 output-full, bit 1 input-full, bit 2 general flag 0, bit 3 command flag, bit 4 general flag 1, bit 5 auxiliary-full, bit 6 general flag 2, bit 7 general flag 3.
- R5: With both strobes low, or with an address other than 0x60 or 0x64, the output enable stays low and no register or flag changes.
- R6: When the flag-enable input is high, a host read at 0x60 clears output-full and the keyboard interrupt. When it is low, that read leaves both unchanged.
- R7: Auxiliary-full and the mouse interrupt are never cleared by a host read. Only a local aux-clear pulse clears them.
- R8: A local output write with the aux mark low loads the output register, sets output-full and raises the keyboard interrupt.
- R9: A local output write with the aux mark high loads the output register, sets output-full and auxiliary-full and raises the mouse interrupt, and leaves the keyboard interrupt unchanged.
- R10: A local input-read pulse clears input-full.
- R11: A strobe held low for many cycles acts only once.
- R12: A local general-flag write loads status bits 2, 4, 6 and 7 from flag bits 0 to 3 in that order.
- R13: When a set and a clear of the same flag fall in the same cycle, the set wins. This covers a local output write against a clearing host data read, and a host write against a local input read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 8 | Host I/O address |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 1 | Host data bus drive enable |
| cfg_flag_en | input | 1 | Host data reads clear output-full and the keyboard interrupt |
| loc_in_data | output | 8 | Input holding register |
| loc_in_cmd | output | 1 | Input byte came through the command address |
| loc_in_rd | input | 1 | Pulse: local side consumed the input byte |
| loc_out_wr | input | 1 | Pulse: load the output holding register |
| loc_out_aux | input | 1 | Output byte belongs to the auxiliary channel |
| loc_out_data | input | 8 | Output byte from the local side |
| loc_aux_clr | input | 1 | Pulse: clear auxiliary-full and the mouse interrupt |
| loc_gp_wr | input | 1 | Pulse: load the general status flags |
| loc_gp_data | input | 4 | General status flag values |
| kbd_irq | output | 1 | Keyboard interrupt request |
| aux_irq | output | 1 | Mouse interrupt request |

## Verification
The hardest situation to reach from the ports is a local set landing in the very cycle a synchronised host strobe takes effect, because the strobe passes through a three-stage synchroniser first. The stimulus drops the strobe just after one clock edge and counts two rising edges. It then raises the local pulse for exactly the following edge. This is done for the output-full flag against a clearing data read, and for input-full against a host write. A second hard case is a strobe held low across a local clear. The stimulus consumes the byte while the write strobe is still low and checks that input-full stays clear.

// File: rtl/kbc_host_if.sv
module kbc_host_if #(
  parameter int          DW        = 8,
  parameter int          AW        = 8,
  parameter int          GPW       = 4,
  parameter logic [AW-1:0] DATA_ADDR = 8'h60,
  parameter logic [AW-1:0] CMD_ADDR  = 8'h64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  input  logic          cfg_flag_en,
  output logic [DW-1:0] loc_in_data,
  output logic          loc_in_cmd,
  input  logic          loc_in_rd,
  input  logic          loc_out_wr,
  input  logic          loc_out_aux,
  input  logic [DW-1:0] loc_out_data,
  input  logic          loc_aux_clr,
  input  logic          loc_gp_wr,
  input  logic [GPW-1:0] loc_gp_data,
  output logic          kbd_irq,
  output logic          aux_irq
);

  localparam int SYNC = 3;

  logic [SYNC-1:0] rd_sy, wr_sy;
  logic [DW-1:0]   in_q, out_q;
  logic            obf, ibf, cd, auxf, kirq, mirq;
  logic [GPW-1:0]  gp;
  logic [DW-1:0]   status;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sy <= '1;
      wr_sy <= '1;
    end else begin
      rd_sy <= {rd_sy[SYNC-2:0], host_rd_n};
      wr_sy <= {wr_sy[SYNC-2:0], host_wr_n};
    end

  wire hit_data    = host_addr == DATA_ADDR;
  wire hit_cmd     = host_addr == CMD_ADDR;
  wire rd_fall     = rd_sy[SYNC-1] & ~rd_sy[SYNC-2] & wr_sy[SYNC-2];
  wire wr_fall     = wr_sy[SYNC-1] & ~wr_sy[SYNC-2] & rd_sy[SYNC-2];
  wire wr_evt      = wr_fall & (hit_data | hit_cmd);
  wire rd_data_evt = rd_fall & hit_data;
  wire rd_clear    = rd_data_evt & cfg_flag_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_q <= '0;
      cd   <= 1'b0;
      ibf  <= 1'b0;
    end else begin
      if (wr_evt) begin
        in_q <= host_wdata;
        cd   <= hit_cmd;
      end
      if (wr_evt)         ibf <= 1'b1;
      else if (loc_in_rd) ibf <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q <= '0;
      obf   <= 1'b0;
      kirq  <= 1'b0;
      auxf  <= 1'b0;
      mirq  <= 1'b0;
      gp    <= '0;
    end else begin
      if (loc_out_wr) out_q <= loc_out_data;

      if (loc_out_wr)    obf <= 1'b1;
      else if (rd_clear) obf <= 1'b0;

      if (loc_out_wr && !loc_out_aux) kirq <= 1'b1;
      else if (rd_clear)              kirq <= 1'b0;

      if (loc_out_wr && loc_out_aux) begin
        auxf <= 1'b1;
        mirq <= 1'b1;
      end else if (loc_aux_clr) begin
        auxf <= 1'b0;
        mirq <= 1'b0;
      end

      if (loc_gp_wr) gp <= loc_gp_data;
    end

  assign status = {gp[3], gp[2], auxf, gp[1], cd, gp[0], ibf, obf};

  assign host_rdata_oe = !host_rd_n && host_wr_n && (hit_data || hit_cmd);
  assign host_rdata    = !host_rdata_oe ? '0 : (hit_cmd ? status : out_q);

  assign loc_in_data = in_q;
  assign loc_in_cmd  = cd;
  assign kbd_irq     = kirq;
  assign aux_irq     = mirq;

endmodule

module kbc_host_if_chk (
  input logic clk,
  input logic rst_n,
  input logic host_rd_n,
  input logic host_wr_n,
  input logic host_rdata_oe,
  input logic wr_evt,
  input logic rd_data_evt,
  input logic cfg_flag_en,
  input logic loc_in_rd,
  input logic loc_out_wr,
  input logic loc_out_aux,
  input logic loc_aux_clr,
  input logic obf,
  input logic ibf,
  input logic auxf,
  input logic kirq,
  input logic mirq
);

  assert_oe_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata_oe |-> (!host_rd_n && host_wr_n));

  assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && rd_data_evt));

  assert_wr_sets_ibf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ibf);

  assert_in_rd_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_in_rd && !wr_evt) |=> !ibf);

  assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && cfg_flag_en && !loc_out_wr) |=> (!obf && !kirq));

  assert_rd_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && !cfg_flag_en && !loc_out_wr) |=> ($stable(obf) && $stable(kirq)));

  assert_aux_only_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(auxf) || $fell(mirq)) |-> $past(loc_aux_clr));

  assert_kbd_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_out_wr && !loc_out_aux) |=> (obf && kirq));

  assert_aux_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_out_wr && loc_out_aux) |=> (obf && auxf && mirq && $stable(kirq)));

  assert_single_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_rd_n    (host_rd_n),
  .host_wr_n    (host_wr_n),
  .host_rdata_oe(host_rdata_oe),
  .wr_evt       (wr_evt),
  .rd_data_evt  (rd_data_evt),
  .cfg_flag_en  (cfg_flag_en),
  .loc_in_rd    (loc_in_rd),
  .loc_out_wr   (loc_out_wr),
  .loc_out_aux  (loc_out_aux),
  .loc_aux_clr  (loc_aux_clr),
  .obf          (obf),
  .ibf          (ibf),
  .auxf         (auxf),
  .kirq         (kirq),
  .mirq         (mirq)
);

// File: tb/sim_kbc_host_if.sv
`timescale 1ns/1ps
module sim_kbc_host_if;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rdata_oe;
  logic       cfg_flag_en = 1'b1;
  logic [7:0] loc_in_data;
  logic       loc_in_cmd;
  logic       loc_in_rd = 1'b0, loc_out_wr = 1'b0, loc_out_aux = 1'b0;
  logic [7:0] loc_out_data = 8'h00;
  logic       loc_aux_clr = 1'b0, loc_gp_wr = 1'b0;
  logic [3:0] loc_gp_data = 4'h0;
  logic       kbd_irq, aux_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kbc_host_if u0 (.*);

  localparam logic [2:0] OP_WD = 3'd0, OP_WC = 3'd1, OP_RD = 3'd2, OP_RS = 3'd3,
                         OP_LK = 3'd4, OP_LA = 3'd5, OP_LR = 3'd6;

  localparam logic [18:0] VEC [12] = '{
    {OP_WD, 8'hA5, 8'h02},
    {OP_LR, 8'h00, 8'h00},
    {OP_WC, 8'hD4, 8'h0A},
    {OP_LR, 8'h00, 8'h08},
    {OP_LK, 8'h3C, 8'h09},
    {OP_RS, 8'h00, 8'h09},
    {OP_RD, 8'h00, 8'h3C},
    {OP_RS, 8'h00, 8'h08},
    {OP_LA, 8'h77, 8'h29},
    {OP_RD, 8'h00, 8'h77},
    {OP_RS, 8'h00, 8'h28},
    {OP_WD, 8'h11, 8'h22}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    host_addr = a; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = host_rdata; oe = host_rdata_oe;
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic status_is(input string req, input logic [7:0] exp);
    logic [7:0] s; logic oe;
    host_rd(8'h64, s, oe);
    chk(req, s, exp);
  endtask

  task automatic loc_pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    loc_out_data = d;
    case (which)
      0: loc_in_rd = 1'b1;
      1: begin loc_out_wr = 1'b1; loc_out_aux = 1'b0; end
      2: begin loc_out_wr = 1'b1; loc_out_aux = 1'b1; end
      3: loc_aux_clr = 1'b1;
      default: begin loc_gp_wr = 1'b1; loc_gp_data = d[3:0]; end
    endcase
    @(negedge clk);
    loc_in_rd = 1'b0; loc_out_wr = 1'b0; loc_out_aux = 1'b0;
    loc_aux_clr = 1'b0; loc_gp_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b; logic oe;
    repeat (3) @(negedge clk);
    chk("R1 kbd_irq", {7'd0, kbd_irq}, 8'h00);
    chk("R1 aux_irq", {7'd0, aux_irq}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 in_data", loc_in_data, 8'h00);
    status_is("R1 status", 8'h00);
    host_rd(8'h60, b, oe);
    chk("R1 out_data", b, 8'h00);

    for (int i = 0; i < 12; i++) begin
      logic [2:0] op; logic [7:0] d, e;
      op = VEC[i][18:16]; d = VEC[i][15:8]; e = VEC[i][7:0];
      case (op)
        OP_WD: begin host_wr(8'h60, d); status_is("R2 table", e); end
        OP_WC: begin host_wr(8'h64, d); status_is("R3 table", e); end
        OP_RD: begin host_rd(8'h60, b, oe); chk("R4 table data", b, e); chk("R4 oe", {7'd0, oe}, 8'h01); end
        OP_RS: begin host_rd(8'h64, b, oe); chk("R4 table status", b, e); end
        OP_LK: begin loc_pulse(1, d); status_is("R8 table", e); end
        OP_LA: begin loc_pulse(2, d); status_is("R9 table", e); end
        default: begin loc_pulse(0, d); status_is("R10 table", e); end
      endcase
    end

    chk("R2 in_data", loc_in_data, 8'h11);
    chk("R2 cmd flag", {7'd0, loc_in_cmd}, 8'h00);
    chk("R9 kbd_irq unchanged", {7'd0, kbd_irq}, 8'h00);
    chk("R7 aux_irq kept after read", {7'd0, aux_irq}, 8'h01);

    loc_pulse(3, 8'h00);
    status_is("R7 aux clear", 8'h02);
    chk("R7 aux_irq cleared", {7'd0, aux_irq}, 8'h00);

    cfg_flag_en = 1'b0;
    loc_pulse(1, 8'h5A);
    chk("R8 kbd_irq", {7'd0, kbd_irq}, 8'h01);
    host_rd(8'h60, b, oe);
    chk("R6 read data", b, 8'h5A);
    status_is("R6 disabled keeps", 8'h03);
    chk("R6 kbd_irq kept", {7'd0, kbd_irq}, 8'h01);
    cfg_flag_en = 1'b1;
    host_rd(8'h60, b, oe);
    status_is("R6 enabled clears", 8'h02);
    chk("R6 kbd_irq cleared", {7'd0, kbd_irq}, 8'h00);

    loc_pulse(4, 8'h0F);
    status_is("R12 flags set", 8'hD6);
    loc_pulse(4, 8'h05);
    status_is("R12 flags 0 and 2", 8'h46);
    loc_pulse(4, 8'h00);

    loc_pulse(0, 8'h00);
    status_is("R10 clear", 8'h00);
    host_wr(8'h61, 8'hEE);
    status_is("R5 other addr write", 8'h00);
    chk("R5 other addr data", loc_in_data, 8'h11);
    host_rd(8'h65, b, oe);
    chk("R5 other addr oe", {7'd0, oe}, 8'h00);

    @(negedge clk);
    host_addr = 8'h64; host_wdata = 8'h99; host_rd_n = 1'b0; host_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 both low oe", {7'd0, host_rdata_oe}, 8'h00);
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    status_is("R5 both low status", 8'h00);
    chk("R5 both low data", loc_in_data, 8'h11);

    @(negedge clk);
    host_addr = 8'h60; host_wdata = 8'h42; host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    loc_in_rd = 1'b1;
    @(negedge clk);
    loc_in_rd = 1'b0;
    repeat (8) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    status_is("R11 held strobe", 8'h00);
    chk("R11 data", loc_in_data, 8'h42);

    @(negedge clk);
    host_addr = 8'h60; host_rd_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    loc_out_wr = 1'b1; loc_out_data = 8'h81;
    @(negedge clk);
    loc_out_wr = 1'b0;
    repeat (3) @(negedge clk);
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    status_is("R13 obf set wins", 8'h01);
    chk("R13 kbd_irq set wins", {7'd0, kbd_irq}, 8'h01);

    @(negedge clk);
    host_addr = 8'h60; host_wdata = 8'h55; host_wr_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    loc_in_rd = 1'b1;
    @(negedge clk);
    loc_in_rd = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    status_is("R13 ibf set wins", 8'h03);
    chk("R13 data", loc_in_data, 8'h55);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    status_is("R1 re-reset status", 8'h00);
    chk("R1 re-reset irq", {6'd0, kbd_irq, aux_irq}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule